// File: doc/BRIEF.md
# Indirect Register Access Port for a Network Controller

This block is the host-facing register window of a network controller. The host sees a few I/O offsets. A pointer register at one offset holds a register index. Two data ports then reach the register that index names: one port serves the control/status register space and the other serves the bus-configuration register space. A third offset is a reset port, and any read of it returns the whole block to its stopped state.

The window has two offset maps. After reset the block uses 16-bit word spacing. The first 32-bit write to the doubleword pointer offset switches the block to doubleword spacing, and it keeps that spacing until the next reset. In both maps only the low 16 bits of an access carry data.

Control register 0 holds the start, stop and initialise commands. It also holds the interrupt enable, the transmit poll demand and an init-done flag. Two read-only registers give a 32-bit identification word. One configuration register selects the descriptor layout, which the block shows on an output pin.

Top module: `nic_regport`

## Requirements
- R1: After the asynchronous reset, control register 0 reads 0x0004, the pointer reads 0, the block is in word mode, every read/write register holds 0 and the outputs `ctl_run`, `tx_poll`, `desc32` and `dword_mode` are low.
- R2: In word mode the control data port is at offset 0x10, the pointer at 0x12, the reset port at 0x14 and the configuration data port at 0x16. A 16-bit write to 0x14 has no effect.
- R3: A write with `bus_dw` high to offset 0x14 while in word mode sets `dword_mode` and loads the pointer. From then on the ports sit at 0x10 (control data), 0x14 (pointer), 0x18 (reset) and 0x1C (configuration data), and the word-mode pointer offset 0x12 reads 0. Write data bits 31:16 are ignored and read data bits 31:16 are 0. The mode holds until a reset.
- R4: The pointer keeps all 16 written bits and reads back the last value written, for example 88.
- R5: A read of the reset port returns 0. At the following clock edge the block returns to the state given in R1, including word mode.
- R6: Writing control register 0 with bit 2 (STOP) set makes it read exactly 0x0004, whatever other bits the write carries.
- R7: Writing bit 0 (INIT) sets bit 0 and clears STOP. Exactly INIT_CYCLES clock edges later, bit 0 clears and bit 8 (init done) sets. Writing 1 to bit 8 clears it.
- R8: Writing 0x0042 sets bit 1 (STRT) and bit 6 (interrupt enable) and clears STOP. `ctl_run` follows STRT. Bit 6 takes the written value on every write without STOP.
- R9: Writing bit 3 (poll demand) while STRT is set, or in the same write that sets it, raises `tx_poll` for exactly the one cycle after the write edge. Bit 3 always reads 0.
- R10: Control registers 88 and 89 read the low and high halves of {4'h0, PART_CODE, 12'h003}. Writes to them are ignored.
- R11: Control registers 1, 2, 3, 4, 5 and 124 and configuration registers 2, 9, 18, 20 and 32 each store 16 bits. The control and configuration spaces are separate, so control register 2 and configuration register 2 are different registers.
- R12: `desc32` is high exactly when bits 7:0 of configuration register 20 equal 2.
- R13: A write to any other index in either space is ignored, and a read of such an index returns 0. An offset that is not mapped in the current mode reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off | input | 5 | Byte offset inside the I/O window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_dw | input | 1 | Access is 32 bits wide |
| bus_wdata | input | 32 | Write data, bits 15:0 used |
| bus_rdata | output | 32 | Read data, valid during `bus_rd`, 0 otherwise |
| dword_mode | output | 1 | Doubleword offset map is active |
| ctl_run | output | 1 | STRT bit of control register 0 |
| tx_poll | output | 1 | One-cycle transmit poll pulse |
| desc32 | output | 1 | 32-bit descriptor layout selected |

## Verification
A behavioural model in the bench follows the pointer, the mode, both register spaces and the command bits. The bench compares the model with the outputs every cycle and with the read data on every read.

- Word-mode and doubleword-mode accesses go to the same indices. This separates the two offset maps and shows that the mode latch is sticky.
- Equal indices written through the control port and the configuration port show whether the two spaces are kept apart.
- Command writes to control register 0 cover INIT, STRT|IENA, poll demand and STOP mixed with other bits, with CSR0 read back every cycle. These show the INIT_CYCLES delay to init done, the one-cycle poll pulse and STOP priority.
- Reset-port reads in both modes show that every piece of state returns to its reset value.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;

  localparam int OFF_W = 5;
  localparam int REG_W = 16;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    PSEL_NONE,
    PSEL_DATA,
    PSEL_PTR,
    PSEL_RESET,
    PSEL_CFG
  } psel_e;

  // word-spaced map
  localparam logic [OFF_W-1:0] W16_DATA  = 5'h10;
  localparam logic [OFF_W-1:0] W16_PTR   = 5'h12;
  localparam logic [OFF_W-1:0] W16_RESET = 5'h14;
  localparam logic [OFF_W-1:0] W16_CFG   = 5'h16;
  // doubleword-spaced map
  localparam logic [OFF_W-1:0] W32_DATA  = 5'h10;
  localparam logic [OFF_W-1:0] W32_PTR   = 5'h14;
  localparam logic [OFF_W-1:0] W32_RESET = 5'h18;
  localparam logic [OFF_W-1:0] W32_CFG   = 5'h1C;

  // control register 0 bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IENA = 6;
  localparam int B_IDON = 8;

  localparam logic [REG_W-1:0] IDX_CTRL  = 16'd0;
  localparam logic [REG_W-1:0] IDX_ID_LO = 16'd88;
  localparam logic [REG_W-1:0] IDX_ID_HI = 16'd89;
  localparam logic [REG_W-1:0] IDX_STYLE = 16'd20;

  localparam int CSR_RW_N = 6;
  localparam logic [CSR_RW_N-1:0][REG_W-1:0] CSR_RW_IDX =
    {16'd124, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1};

  localparam int BCR_RW_N = 5;
  localparam logic [BCR_RW_N-1:0][REG_W-1:0] BCR_RW_IDX =
    {16'd32, 16'd20, 16'd18, 16'd9, 16'd2};

  function automatic int style_slot();
    for (int i = 0; i < BCR_RW_N; i++) begin
      if (BCR_RW_IDX[i] == IDX_STYLE) return i;
    end
    return 0;
  endfunction

  localparam int STYLE_SLOT = style_slot();

endpackage

// File: rtl/nic_regport_decode.sv
module nic_regport_decode
  import nic_regport_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic             dword_q,
  input  logic             wr,
  input  logic             dw,
  output psel_e            psel,
  output logic             dw_latch
);

  logic eff_dw;

  // a 32-bit pointer write in word mode switches maps in the same access
  assign dw_latch = wr && dw && (off == W32_PTR) && !dword_q;
  assign eff_dw   = dword_q || dw_latch;

  always_comb begin
    psel = PSEL_NONE;
    if (eff_dw) begin
      case (off)
        W32_DATA:  psel = PSEL_DATA;
        W32_PTR:   psel = PSEL_PTR;
        W32_RESET: psel = PSEL_RESET;
        W32_CFG:   psel = PSEL_CFG;
        default:   psel = PSEL_NONE;
      endcase
    end else begin
      case (off)
        W16_DATA:  psel = PSEL_DATA;
        W16_PTR:   psel = PSEL_PTR;
        W16_RESET: psel = PSEL_RESET;
        W16_CFG:   psel = PSEL_CFG;
        default:   psel = PSEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nic_regport_bank.sv
module nic_regport_bank
  import nic_regport_pkg::*;
#(
  parameter int                        N   = 2,
  parameter logic [N-1:0][REG_W-1:0]   IDX = {16'd2, 16'd1}
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [REG_W-1:0]          ptr,
  input  logic [REG_W-1:0]          wd,
  output logic [REG_W-1:0]          rd,
  output logic [N-1:0][REG_W-1:0]   vals
);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] d;
    logic             en;

    assign hit[i] = (ptr == IDX[i]);
    assign en     = clr || (wr && hit[i]);
    assign d      = clr ? '0 : wd;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign vals[i] = q;
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) rd = rd | vals[i];
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R11

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(wr && (|hit))) |=> $stable(vals)); // R13

endmodule

// File: rtl/nic_regport_ctl.sv
module nic_regport_ctl
  import nic_regport_pkg::*;
#(
  parameter int INIT_CYCLES = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [REG_W-1:0] wd,
  output logic [REG_W-1:0] csr0,
  output logic             run,
  output logic             tx_poll
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic             init_q, strt_q, stop_q, iena_q, idon_q, poll_q;
  logic             init_d, strt_d, stop_d, iena_d, idon_d, poll_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done, en;

  assign done = (cnt_q == CNT_W'(1));
  assign en   = clr || wr || (cnt_q != '0) || poll_q;

  always_comb begin
    init_d = init_q;
    strt_d = strt_q;
    stop_d = stop_q;
    iena_d = iena_q;
    idon_d = idon_q;
    cnt_d  = cnt_q;
    poll_d = 1'b0;
    if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    if (done) begin
      init_d = 1'b0;
      idon_d = 1'b1;
    end
    if (clr || (wr && wd[B_STOP])) begin
      stop_d = 1'b1;
      strt_d = 1'b0;
      init_d = 1'b0;
      iena_d = 1'b0;
      idon_d = 1'b0;
      cnt_d  = '0;
    end else if (wr) begin
      if (wd[B_INIT]) begin
        init_d = 1'b1;
        stop_d = 1'b0;
        cnt_d  = CNT_W'(INIT_CYCLES);
        idon_d = idon_q && !wd[B_IDON];
      end else if (wd[B_IDON]) begin
        idon_d = done;
      end
      if (wd[B_STRT]) begin
        strt_d = 1'b1;
        stop_d = 1'b0;
      end
      iena_d = wd[B_IENA];
      poll_d = wd[B_TDMD] && (strt_q || wd[B_STRT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      strt_q <= 1'b0;
      stop_q <= 1'b1;
      iena_q <= 1'b0;
      idon_q <= 1'b0;
      poll_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      init_q <= init_d;
      strt_q <= strt_d;
      stop_q <= stop_d;
      iena_q <= iena_d;
      idon_q <= idon_d;
      poll_q <= poll_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    csr0         = '0;
    csr0[B_INIT] = init_q;
    csr0[B_STRT] = strt_q;
    csr0[B_STOP] = stop_q;
    csr0[B_IENA] = iena_q;
    csr0[B_IDON] = idon_q;
  end

  assign run     = strt_q;
  assign tx_poll = poll_q;

  AST_STOP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!strt_q && !init_q && !iena_q && !idon_q)); // R6

  AST_CLR_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (csr0 == 16'h0004)); // R5

  AST_IDON_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && !(wr && (wd[B_INIT] || wd[B_STOP]))) |=> (idon_q && !init_q)); // R7

  AST_POLL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> run); // R9

endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter logic [15:0] PART_CODE   = 16'h2625,
  parameter int          INIT_CYCLES = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] bus_off,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_dw,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             dword_mode,
  output logic             ctl_run,
  output logic             tx_poll,
  output logic             desc32
);

  localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, 12'h003};

  psel_e            psel;
  logic             dw_latch, clr;
  logic             wr_ptr, wr_data, wr_cfg, wr_ctrl;
  logic             dword_q, dword_d, dword_en;
  logic [REG_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic [REG_W-1:0] wd16, csr0, csr_bank_rd, bcr_rd, csr_rd;
  logic [CSR_RW_N-1:0][REG_W-1:0] csr_vals;
  logic [BCR_RW_N-1:0][REG_W-1:0] bcr_vals;
  logic             unused_bits;

  nic_regport_decode u_dec (
    .off      (bus_off),
    .dword_q  (dword_q),
    .wr       (bus_wr),
    .dw       (bus_dw),
    .psel     (psel),
    .dw_latch (dw_latch)
  );

  assign wd16    = bus_wdata[REG_W-1:0];
  assign clr     = bus_rd && (psel == PSEL_RESET);
  assign wr_ptr  = bus_wr && !clr && (psel == PSEL_PTR);
  assign wr_data = bus_wr && !clr && (psel == PSEL_DATA);
  assign wr_cfg  = bus_wr && !clr && (psel == PSEL_CFG);
  assign wr_ctrl = wr_data && (ptr_q == IDX_CTRL);

  // mode latch
  assign dword_en = clr || dw_latch;
  assign dword_d  = !clr;

  // pointer register
  assign ptr_en = clr || wr_ptr;
  assign ptr_d  = clr ? '0 : wd16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dword_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (dword_en) dword_q <= dword_d;
      if (ptr_en)   ptr_q   <= ptr_d;
    end
  end

  nic_regport_ctl #(.INIT_CYCLES(INIT_CYCLES)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr      (wr_ctrl),
    .wd      (wd16),
    .csr0    (csr0),
    .run     (ctl_run),
    .tx_poll (tx_poll)
  );

  nic_regport_bank #(.N(CSR_RW_N), .IDX(CSR_RW_IDX)) u_csr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (wr_data),
    .ptr   (ptr_q),
    .wd    (wd16),
    .rd    (csr_bank_rd),
    .vals  (csr_vals)
  );

  nic_regport_bank #(.N(BCR_RW_N), .IDX(BCR_RW_IDX)) u_bcr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (wr_cfg),
    .ptr   (ptr_q),
    .wd    (wd16),
    .rd    (bcr_rd),
    .vals  (bcr_vals)
  );

  always_comb begin
    case (ptr_q)
      IDX_CTRL:  csr_rd = csr0;
      IDX_ID_LO: csr_rd = ID_WORD[15:0];
      IDX_ID_HI: csr_rd = ID_WORD[31:16];
      default:   csr_rd = csr_bank_rd;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (psel)
        PSEL_DATA: bus_rdata[REG_W-1:0] = csr_rd;
        PSEL_PTR:  bus_rdata[REG_W-1:0] = ptr_q;
        PSEL_CFG:  bus_rdata[REG_W-1:0] = bcr_rd;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign dword_mode  = dword_q;
  assign desc32      = (bcr_vals[STYLE_SLOT][7:0] == 8'd2);
  assign unused_bits = ^{bus_wdata[BUS_W-1:REG_W], csr_vals, bcr_vals};

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dword_q && !clr) |=> dword_q); // R3

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> (ptr_q == $past(wd16))); // R4

  AST_RESET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0 && !dword_q)); // R5

endmodule

// File: tb/nic_regport_test.sv
module nic_regport_test;

  localparam int INIT_CYCLES = 4;
  localparam int PART        = 'h2625;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_off;
  logic        bus_rd, bus_wr, bus_dw;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dword_mode, ctl_run, tx_poll, desc32;

  always #5 clk = ~clk;

  nic_regport #(.PART_CODE(16'h2625), .INIT_CYCLES(INIT_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_dw(bus_dw), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dword_mode(dword_mode), .ctl_run(ctl_run),
    .tx_poll(tx_poll), .desc32(desc32)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  int m_dw, m_ptr, m_stop, m_strt, m_init, m_iena, m_idon, m_cnt, m_poll;
  int m_csr[int];
  int m_bcr[int];

  task automatic model_reset();
    m_dw = 0; m_ptr = 0; m_stop = 1; m_strt = 0; m_init = 0;
    m_iena = 0; m_idon = 0; m_cnt = 0; m_poll = 0;
    m_csr.delete(); m_bcr.delete();
  endtask

  function automatic bit csr_rw(int i);
    return (i inside {1, 2, 3, 4, 5, 124});
  endfunction

  function automatic bit bcr_rw(int i);
    return (i inside {2, 9, 18, 20, 32});
  endfunction

  function automatic int csr_val(int i);
    if (i == 0)  return (m_idon << 8) | (m_iena << 6) | (m_stop << 2) | (m_strt << 1) | m_init;
    if (i == 88) return ((PART & 'hF) << 12) | 'h003;
    if (i == 89) return PART >> 4;
    if (csr_rw(i) && m_csr.exists(i)) return m_csr[i];
    return 0;
  endfunction

  function automatic int bcr_val(int i);
    if (bcr_rw(i) && m_bcr.exists(i)) return m_bcr[i];
    return 0;
  endfunction

  // 0 none, 1 control data, 2 pointer, 3 reset, 4 config data
  function automatic int port_of(int off, int dwm);
    if (dwm != 0) begin
      if (off == 'h10) return 1;
      if (off == 'h14) return 2;
      if (off == 'h18) return 3;
      if (off == 'h1C) return 4;
    end else begin
      if (off == 'h10) return 1;
      if (off == 'h12) return 2;
      if (off == 'h14) return 3;
      if (off == 'h16) return 4;
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic status_check();
    chk("R3 dword_mode", int'(dword_mode), m_dw);
    chk("R8 ctl_run", int'(ctl_run), m_strt);
    chk("R9 tx_poll", int'(tx_poll), m_poll);
    chk("R12 desc32", int'(desc32), ((bcr_val(20) & 'hFF) == 2) ? 1 : 0);
  endtask

  // one bus cycle; entered and left just after a falling edge
  task automatic step(input int off, input bit rd, input bit wr, input bit dw,
                      input logic [31:0] wd, input string tag);
    int p, effdw, wv, exp, fin, old_idon, old_strt, pnew;
    bus_off = off[4:0]; bus_rd = rd; bus_wr = wr; bus_dw = dw; bus_wdata = wd;
    #1;
    effdw = (m_dw != 0 || (wr && dw && off == 'h14)) ? 1 : 0;
    p = port_of(off, effdw);
    if (rd) begin
      exp = (p == 1) ? csr_val(m_ptr) : (p == 2) ? m_ptr : (p == 4) ? bcr_val(m_ptr) : 0;
      chk(tag, int'(bus_rdata), exp);
    end
    @(posedge clk);
    wv = int'(wd[15:0]);
    if (rd && p == 3) begin
      model_reset();
    end else begin
      fin = (m_cnt == 1) ? 1 : 0;
      old_idon = m_idon; old_strt = m_strt; pnew = 0;
      if (m_cnt > 0) m_cnt--;
      if (fin != 0) begin m_init = 0; m_idon = 1; end
      if (wr && dw && off == 'h14) m_dw = 1;
      if (wr && p == 1 && csr_rw(m_ptr)) m_csr[m_ptr] = wv;
      if (wr && p == 4 && bcr_rw(m_ptr)) m_bcr[m_ptr] = wv;
      if (wr && p == 1 && m_ptr == 0) begin
        if ((wv & 'h4) != 0) begin
          m_stop = 1; m_strt = 0; m_init = 0; m_iena = 0; m_idon = 0; m_cnt = 0;
        end else begin
          if ((wv & 'h1) != 0) begin
            m_init = 1; m_stop = 0; m_cnt = INIT_CYCLES;
            m_idon = (old_idon != 0 && (wv & 'h100) == 0) ? 1 : 0;
          end else if ((wv & 'h100) != 0) begin
            m_idon = fin;
          end
          if ((wv & 'h2) != 0) begin m_strt = 1; m_stop = 0; end
          m_iena = (wv >> 6) & 1;
          pnew = ((wv & 'h8) != 0 && (old_strt != 0 || (wv & 'h2) != 0)) ? 1 : 0;
        end
      end
      if (wr && p == 2) m_ptr = wv;
      m_poll = pnew;
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_dw = 0;
    status_check();
  endtask

  task automatic wr16(input int off, input logic [31:0] v, input string tag);
    step(off, 1'b0, 1'b1, 1'b0, v, tag);
  endtask
  task automatic wr32(input int off, input logic [31:0] v, input string tag);
    step(off, 1'b0, 1'b1, 1'b1, v, tag);
  endtask
  task automatic rd16(input int off, input string tag);
    step(off, 1'b1, 1'b0, 1'b0, 32'h0, tag);
  endtask
  task automatic rd32(input int off, input string tag);
    step(off, 1'b1, 1'b0, 1'b1, 32'h0, tag);
  endtask
  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_off = '0; bus_rd = 0; bus_wr = 0; bus_dw = 0; bus_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    status_check();                                   // R1 outputs
    rd16('h12, "R1 pointer after reset");
    rd16('h10, "R1 csr0 after reset");
    rd16('h16, "R1 bcr0 after reset");

    // pointer and identification
    wr16('h12, 88, "R4 ptr write");
    rd16('h12, "R4 ptr readback 88");
    rd16('h10, "R10 id low");
    wr16('h10, 32'hFFFF, "R10 id write");
    rd16('h10, "R10 id low after write");
    wr16('h12, 89, "R4 ptr write");
    rd16('h10, "R10 id high");
    wr16('h12, 32'hBEEF, "R4 ptr all bits");
    rd16('h12, "R4 ptr readback wide");

    // separate spaces at index 2
    wr16('h12, 2, "R11 ptr");
    wr16('h10, 32'h1111, "R11 csr2 write");
    wr16('h16, 32'h2222, "R11 bcr2 write");
    rd16('h10, "R11 csr2 read");
    rd16('h16, "R11 bcr2 read");
    wr16('h12, 124, "R11 ptr");
    wr16('h10, 32'hA5C3, "R11 csr124 write");
    rd16('h10, "R11 csr124 read");

    // descriptor style
    wr16('h12, 20, "R12 ptr");
    wr16('h16, 32'h0002, "R12 style 32");
    rd16('h16, "R12 bcr20 read");
    wr16('h16, 32'h0102, "R12 style upper byte");
    wr16('h16, 32'h0000, "R12 style 16");

    // unimplemented indices and offsets
    wr16('h12, 7, "R13 ptr");
    wr16('h10, 32'h7777, "R13 csr7 write");
    wr16('h16, 32'h7777, "R13 bcr7 write");
    rd16('h10, "R13 csr7 read");
    rd16('h16, "R13 bcr7 read");
    rd16('h18, "R13 unmapped word offset");
    rd16('h1C, "R13 unmapped word offset");
    wr16('h14, 32'h0033, "R2 word write to reset port");
    rd16('h12, "R2 ptr unchanged");

    // control register 0 sequencing
    wr16('h12, 0, "R7 ptr");
    wr16('h10, 32'h0001, "R7 init");
    for (int i = 0; i < INIT_CYCLES + 1; i++) rd16('h10, "R7 init progress");
    wr16('h10, 32'h0100, "R7 idon clear");
    rd16('h10, "R7 idon cleared");
    wr16('h10, 32'h0042, "R8 start");
    rd16('h10, "R8 csr0 running");
    wr16('h10, 32'h0048, "R9 poll demand");
    rd16('h10, "R9 tdmd reads 0");
    wr16('h10, 32'h0002, "R8 iena follows write");
    rd16('h10, "R8 iena cleared");
    wr16('h10, 32'h0147, "R6 stop with others");
    rd16('h10, "R6 csr0 stopped");
    wr16('h10, 32'h0008, "R9 poll while stopped");
    rd16('h10, "R9 no start");
    wr16('h10, 32'h000A, "R9 start with poll");
    wr16('h10, 32'h0001, "R7 init while running");
    wr16('h10, 32'h0004, "R6 stop aborts init");
    for (int i = 0; i < INIT_CYCLES + 1; i++) rd16('h10, "R6 no idon after stop");

    // reset port in word mode
    wr16('h12, 3, "R5 ptr");
    wr16('h10, 32'h5A5A, "R5 csr3");
    wr16('h10, 32'h0000, "R5 csr3 w0");
    wr16('h10, 32'h5A5A, "R5 csr3");
    wr16('h12, 0, "R5 ptr");
    wr16('h10, 32'h0042, "R5 start");
    rd16('h14, "R5 reset port reads 0");
    rd16('h10, "R5 csr0 after soft reset");
    wr16('h12, 3, "R5 ptr");
    rd16('h10, "R5 csr3 cleared");

    // doubleword mode
    wr32('h14, 88, "R3 latch dword");
    rd32('h14, "R3 dword ptr read");
    rd16('h12, "R3 old ptr offset");
    rd32('h10, "R3 id via dword");
    wr32('h14, 3, "R3 ptr");
    wr32('h10, 32'hFFFF1234, "R3 upper bits ignored");
    rd32('h10, "R3 csr3 dword");
    wr32('h14, 20, "R3 ptr");
    wr32('h1C, 32'hABCD0002, "R12 style via dword");
    rd32('h1C, "R3 bcr20 dword");
    wr16('h14, 9, "R3 word write at dword ptr");
    rd32('h14, "R3 ptr 9");
    rd32('h16, "R13 unmapped dword offset");
    rd32('h18, "R5 dword reset reads 0");
    rd16('h12, "R5 word map restored");
    rd16('h10, "R5 csr0 stopped");

    summary();
    $finish;
  end

endmodule